// File: doc/BRIEF.md
# Carry-Zero Arithmetic and NOR Unit

This is a purely combinational datapath unit for a small 8-bit core. The core presents two operands and a 3-bit operation code. The unit returns the computed value, the next values of the carry and zero flags, and three write strobes. The strobes tell the core whether to update its destination register, its carry flag and its zero flag. The unit holds no state. The core picks which register (accumulator or index) receives the result, and it keeps any flag whose strobe is low.

The operation set is small. It has addition and subtraction that produce a carry-out without taking a carry-in, and a compare that shares the subtract path. It has a bitwise NOR as the only logic function, plus a pass-through for loads. It also has increment and decrement, which act on the first operand. For the subtractive operations, a carry of one means no borrow occurred.

Top module: `cz_alu`

## Requirements
- R1: With op code 0 (add), result is (a + b) mod 256, carry_nxt is bit 8 of the unsigned sum, and all three strobes res_wr, carry_wr and zero_wr are 1.
- R2: With op code 1 (subtract), result is (a - b) mod 256, carry_nxt is 1 exactly when a >= b as unsigned numbers, and all three strobes are 1.
- R3: With op code 2 (compare), carry_nxt and zero_nxt equal those of a subtract of the same operands, carry_wr and zero_wr are 1, and res_wr is 0.
- R4: With op code 3 (NOR), result is the bitwise NOR of a and b, zero_wr is 1, and res_wr is 1 while carry_wr is 0.
- R5: With op code 4 (load pass-through), result equals b, res_wr and zero_wr are 1, and carry_wr is 0.
- R6: With op code 5 (increment), result is (a + 1) mod 256, so 0xFF gives 0x00. Operand b has no effect on the result. res_wr and zero_wr are 1 and carry_wr is 0.
- R7: With op code 6 (decrement), result is (a - 1) mod 256, so 0x00 gives 0xFF. Operand b has no effect on the result. res_wr and zero_wr are 1 and carry_wr is 0.
- R8: For every operation code from 0 to 6, zero_nxt is 1 exactly when the computed 8-bit value is zero. For compare, that value is the difference.
- R9: Op code 7 is unassigned and drives all three strobes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 8 | First operand (accumulator or index register) |
| opd_b | input | 8 | Second operand (memory or immediate byte) |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Computed value |
| carry_nxt | output | 1 | Next carry flag value |
| zero_nxt | output | 1 | Next zero flag value |
| res_wr | output | 1 | Write strobe for the destination register |
| carry_wr | output | 1 | Write strobe for the carry flag |
| zero_wr | output | 1 | Write strobe for the zero flag |

## Verification
The hardest case is a compare, because its difference never reaches the result strobe. Its flags must still follow that hidden value through the borrow boundary, where a equals b and then differs by one in either direction. The stimulus covers this with directed equal and off-by-one pairs for compare and subtract. It then sweeps operand pairs whose differences wrap through zero across all eight codes. Increment and decrement are also driven with a nonzero b, which shows at the result port that b is ignored.

// File: rtl/cz_alu_pkg.sv
package cz_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_CMP  = 3'd2,
        ALU_NOR  = 3'd3,
        ALU_PASS = 3'd4,
        ALU_INC  = 3'd5,
        ALU_DEC  = 3'd6,
        ALU_NONE = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_SUM = 2'd0,
        SRC_NOR = 2'd1,
        SRC_OPB = 2'd2
    } res_src_e;

    typedef struct packed {
        logic res;
        logic c;
        logic z;
    } wb_t;

    typedef struct packed {
        logic     use_one;  // replace operand b by constant one
        logic     invert;   // ones-complement the adder's second input
        logic     cin;      // constant carry into the adder
        res_src_e src;
        wb_t      wb;
    } ctrl_t;

    function automatic ctrl_t decode_op(alu_op_e op);
        ctrl_t c;
        c = '{use_one: 1'b0, invert: 1'b0, cin: 1'b0, src: SRC_OPB,
              wb: '{res: 1'b0, c: 1'b0, z: 1'b0}};
        unique case (op)
            ALU_ADD: begin
                c.src = SRC_SUM;
                c.wb  = '{res: 1'b1, c: 1'b1, z: 1'b1};
            end
            ALU_SUB: begin
                c.src    = SRC_SUM;
                c.invert = 1'b1;
                c.cin    = 1'b1;
                c.wb     = '{res: 1'b1, c: 1'b1, z: 1'b1};
            end
            ALU_CMP: begin
                c.src    = SRC_SUM;
                c.invert = 1'b1;
                c.cin    = 1'b1;
                c.wb     = '{res: 1'b0, c: 1'b1, z: 1'b1};
            end
            ALU_NOR: begin
                c.src = SRC_NOR;
                c.wb  = '{res: 1'b1, c: 1'b0, z: 1'b1};
            end
            ALU_PASS: begin
                c.src = SRC_OPB;
                c.wb  = '{res: 1'b1, c: 1'b0, z: 1'b1};
            end
            ALU_INC: begin
                c.src     = SRC_SUM;
                c.use_one = 1'b1;
                c.wb      = '{res: 1'b1, c: 1'b0, z: 1'b1};
            end
            ALU_DEC: begin
                c.src     = SRC_SUM;
                c.use_one = 1'b1;
                c.invert  = 1'b1;
                c.cin     = 1'b1;
                c.wb      = '{res: 1'b1, c: 1'b0, z: 1'b1};
            end
            default: begin
                c.src = SRC_OPB;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cz_dec.sv
module cz_dec
    import cz_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl = decode_op(alu_op_e'(op_code));
    end

endmodule

// File: rtl/cz_add.sv
module cz_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int FW = W + 1;

    logic [FW-1:0] full;
    logic [W-1:0]  b_eff;

    assign b_eff = b ^ {W{invert}};
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    assign sum   = full[W-1:0];
    assign cout  = full[FW-1];

endmodule

// File: rtl/cz_nor.sv
module cz_nor #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = ~(a[i] | b[i]);
    end

endmodule

// File: rtl/cz_alu.sv
module cz_alu
    import cz_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [2:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic              carry_nxt,
    output logic              zero_nxt,
    output logic              res_wr,
    output logic              carry_wr,
    output logic              zero_wr
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    ctrl_t             ctrl;
    logic [DATA_W-1:0] add_in_b;
    logic [DATA_W-1:0] sum_v;
    logic              sum_c;
    logic [DATA_W-1:0] nor_v;

    cz_dec u_dec (
        .op_code (op_sel),
        .ctrl    (ctrl)
    );

    assign add_in_b = ctrl.use_one ? ONE : opd_b;

    cz_add #(.W(DATA_W)) u_add (
        .a      (opd_a),
        .b      (add_in_b),
        .invert (ctrl.invert),
        .cin    (ctrl.cin),
        .sum    (sum_v),
        .cout   (sum_c)
    );

    cz_nor #(.W(DATA_W)) u_nor (
        .a (opd_a),
        .b (opd_b),
        .y (nor_v)
    );

    always_comb begin
        unique case (ctrl.src)
            SRC_SUM: result = sum_v;
            SRC_NOR: result = nor_v;
            default: result = opd_b;
        endcase
    end

    assign carry_nxt = sum_c;
    assign zero_nxt  = ~|result;
    assign res_wr    = ctrl.wb.res;
    assign carry_wr  = ctrl.wb.c;
    assign zero_wr   = ctrl.wb.z;

endmodule

// File: rtl/cz_alu_chk.sv
module cz_alu_chk
    import cz_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [2:0]   op,
    input logic [W-1:0] res,
    input logic         c,
    input logic         z,
    input logic         rw,
    input logic         cw,
    input logic         zw
);

    localparam logic [W-1:0] K1 = {{(W-1){1'b0}}, 1'b1};

    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        if (alu_op_e'(op) == ALU_ADD) begin
            // R1
            add_sum_chk: assert ({c, res} == wide_sum && rw && cw && zw)
                else $error("add_sum_chk");
        end
        if (alu_op_e'(op) == ALU_SUB) begin
            // R2
            sub_borrow_chk: assert (c == (a >= b) && res == a - b && rw && cw && zw)
                else $error("sub_borrow_chk");
        end
        if (alu_op_e'(op) == ALU_CMP) begin
            // R3
            cmp_nowrite_chk: assert (!rw && cw && zw && c == (a >= b) && z == (a == b))
                else $error("cmp_nowrite_chk");
        end
        if (alu_op_e'(op) == ALU_NOR) begin
            // R4
            nor_zonly_chk: assert (res == ~(a | b) && rw && !cw && zw)
                else $error("nor_zonly_chk");
        end
        if (alu_op_e'(op) == ALU_PASS) begin
            // R5
            pass_chk: assert (res == b && rw && !cw && zw)
                else $error("pass_chk");
        end
        if (alu_op_e'(op) == ALU_INC) begin
            // R6
            inc_wrap_chk: assert (res == a + K1 && rw && !cw && zw)
                else $error("inc_wrap_chk");
        end
        if (alu_op_e'(op) == ALU_DEC) begin
            // R7
            dec_wrap_chk: assert (res == a - K1 && rw && !cw && zw)
                else $error("dec_wrap_chk");
        end
        if (alu_op_e'(op) != ALU_NONE) begin
            // R8
            zero_flag_chk: assert (z == (res == '0))
                else $error("zero_flag_chk");
        end
        if (alu_op_e'(op) == ALU_NONE) begin
            // R9
            idle_strobe_chk: assert (!rw && !cw && !zw)
                else $error("idle_strobe_chk");
        end
    end

endmodule

bind cz_alu cz_alu_chk #(.W(DATA_W)) u_chk (
    .a   (opd_a),
    .b   (opd_b),
    .op  (op_sel),
    .res (result),
    .c   (carry_nxt),
    .z   (zero_nxt),
    .rw  (res_wr),
    .cw  (carry_wr),
    .zw  (zero_wr)
);

// File: tb/sim_cz_alu.sv
module sim_cz_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [2:0] op_in = 3'd7;
    logic [7:0] result;
    logic       carry_nxt, zero_nxt, res_wr, carry_wr, zero_wr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic       c;
        logic       z;
        logic [2:0] wb;
        bit         chk_res;
        bit         chk_c;
        bit         chk_z;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    cz_alu u0 (
        .opd_a     (a_in),
        .opd_b     (b_in),
        .op_sel    (op_in),
        .result    (result),
        .carry_nxt (carry_nxt),
        .zero_nxt  (zero_nxt),
        .res_wr    (res_wr),
        .carry_wr  (carry_wr),
        .zero_wr   (zero_wr)
    );

    function automatic exp_t model(input logic [2:0] op, input logic [7:0] a,
                                   input logic [7:0] b);
        exp_t e;
        int ia, ib, r;
        ia = int'(a);
        ib = int'(b);
        r  = 0;
        e.op = op; e.a = a; e.b = b; e.c = 1'b0;
        e.chk_res = 1; e.chk_c = 0; e.chk_z = 1;
        case (op)
            3'd0: begin r = (ia + ib) % 256; e.c = (ia + ib) > 255;
                        e.wb = 3'b111; e.chk_c = 1; e.tag = "R1"; end
            3'd1: begin r = (ia - ib + 256) % 256; e.c = (ia >= ib);
                        e.wb = 3'b111; e.chk_c = 1; e.tag = "R2"; end
            3'd2: begin r = (ia - ib + 256) % 256; e.c = (ia >= ib);
                        e.wb = 3'b011; e.chk_c = 1; e.chk_res = 0; e.tag = "R3"; end
            3'd3: begin r = 255 - (ia | ib); e.wb = 3'b101; e.tag = "R4"; end
            3'd4: begin r = ib; e.wb = 3'b101; e.tag = "R5"; end
            3'd5: begin r = (ia + 1) % 256; e.wb = 3'b101; e.tag = "R6"; end
            3'd6: begin r = (ia + 255) % 256; e.wb = 3'b101; e.tag = "R7"; end
            default: begin e.wb = 3'b000; e.chk_res = 0; e.chk_z = 0; e.tag = "R9"; end
        endcase
        e.res = 8'(r);
        e.z   = (r == 0);
        return e;
    endfunction

    task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        op_in = op;
        a_in  = a;
        b_in  = b;
        sb.push_back(model(op, a, b));
    endtask

    task automatic report_summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: samples at the falling edge, half a period after inputs change
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if ({res_wr, carry_wr, zero_wr} !== e.wb) begin
                    n_bad++;
                    $display("FAIL %s strobes op=%0d a=%h b=%h actual=%b expected=%b",
                             e.tag, e.op, e.a, e.b, {res_wr, carry_wr, zero_wr}, e.wb);
                end
                if (e.chk_res) begin
                    n_cmp++;
                    if (result !== e.res) begin
                        n_bad++;
                        $display("FAIL %s result op=%0d a=%h b=%h actual=%h expected=%h",
                                 e.tag, e.op, e.a, e.b, result, e.res);
                    end
                end
                if (e.chk_c) begin
                    n_cmp++;
                    if (carry_nxt !== e.c) begin
                        n_bad++;
                        $display("FAIL %s carry op=%0d a=%h b=%h actual=%b expected=%b",
                                 e.tag, e.op, e.a, e.b, carry_nxt, e.c);
                    end
                end
                if (e.chk_z) begin
                    n_cmp++;
                    if (zero_nxt !== e.z) begin   // R8
                        n_bad++;
                        $display("FAIL R8 zero op=%0d a=%h b=%h actual=%b expected=%b",
                                 e.op, e.a, e.b, zero_nxt, e.z);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report_summary();
    end

    initial begin
        // reset state: unassigned code holds all strobes low (R9)
        drive(3'd7, 8'h55, 8'hAA);
        drive(3'd7, 8'h00, 8'h00);
        @(posedge clk);
        rst = 1'b0;

        // R1: carry out and zero at wrap
        drive(3'd0, 8'hFF, 8'h01);
        drive(3'd0, 8'h80, 8'h80);
        drive(3'd0, 8'h12, 8'h34);
        // R2: equal, borrow boundary
        drive(3'd1, 8'h05, 8'h05);
        drive(3'd1, 8'h03, 8'h04);
        drive(3'd1, 8'h04, 8'h03);
        drive(3'd1, 8'h00, 8'hFF);
        // R3: compare, no write-back
        drive(3'd2, 8'h10, 8'h20);
        drive(3'd2, 8'h20, 8'h20);
        drive(3'd2, 8'h21, 8'h20);
        // R4: NOR
        drive(3'd3, 8'hF0, 8'h0F);
        drive(3'd3, 8'h00, 8'h00);
        drive(3'd3, 8'hA5, 8'h0C);
        // R5: pass-through
        drive(3'd4, 8'h77, 8'h00);
        drive(3'd4, 8'h00, 8'hC3);
        // R6: increment wraps, b ignored
        drive(3'd5, 8'hFF, 8'hAA);
        drive(3'd5, 8'h41, 8'h7E);
        // R7: decrement wraps, b ignored
        drive(3'd6, 8'h00, 8'h5A);
        drive(3'd6, 8'h01, 8'hFF);
        // R9
        drive(3'd7, 8'h01, 8'h01);

        // sweep of operand pairs across every code
        for (int op = 0; op < 8; op++) begin
            for (int ia = 0; ia < 256; ia += 17) begin
                for (int ib = 0; ib < 256; ib += 51) begin
                    drive(3'(op), 8'(ia), 8'(ib));
                    drive(3'(op), 8'(ia), 8'(ia + ib / 51 - 2));
                end
            end
        end

        @(posedge clk);
        @(posedge clk);
        wait (sb.size() == 0);
        @(posedge clk);
        report_summary();
    end

endmodule